// File: doc/BRIEF.md
# Eight-Phase Polynomial Upsampling Interpolator

This block raises a stream's sample rate by eight. Each accepted input sample moves a cubic fractional-delay filter forward by one step. The block then emits eight interpolated samples, one on each cycle, for eight fixed sub-sample positions one eighth of a sample apart. The filter has the polynomial-in-offset form. Four constant 4-tap subfilters C0..C3 run once per input. Each phase output is C0 + d·C1 + d²·C2 + d³·C3, where d = (k − 4)/8 is the offset of phase k from the 1.5-sample midpoint.

No product in the block uses a general multiplier. The input feeds one shift-and-add network that builds every bank constant and reuses partial sums. The four subfilters use the transposed form, so that one network serves all sixteen taps. The per-phase weights d, d² and d³ are small integers times powers of two. They are applied by selecting among shifted copies of shared sums such as 3·C and 27·C. A two-state machine controls the block. In `LOAD_WAIT` it accepts a sample. In `BURST` it walks the phase counter from 0 to 7 and then returns to `LOAD_WAIT`. The transitions are named *accept* (`LOAD_WAIT`→`BURST` on `in_valid`), *step* (`BURST`→`BURST` while the phase is below 7) and *drain* (`BURST`→`LOAD_WAIT` after phase 7).

Top module: `farrow_x8_interp`

## Requirements
- R1: A synchronous reset sets `in_ready`=1, `out_valid`=0 and the phase counter to 0, and clears all filter state to zero. The first burst after reset therefore depends only on samples accepted after the reset, even when the reset arrives in the middle of a burst.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the cycle after phase 7 has been presented.
- R3: After an accept, `out_valid` is 1 for exactly eight consecutive cycles, starting on the next cycle. `out_phase` counts 0,1,…,7 in those cycles. Phase k stands for offset d=(k−4)/8, and phase 0 is d=−0.5.
- R4: `in_valid` and `in_sample` have no effect while a burst is running. The burst outputs and all later outputs are the same as if the input had stayed idle.
- R5: Let x0 be the newest accepted sample and x1..x3 the older ones. Subfilter m is Cm = Σn cm(n)·xn, with the integer coefficients (scale 2048) c0 = {−128, 1152, 1152, −128}, c1 = {85, −2304, 2304, −85}, c2 = {512, −512, −512, 512}, c3 = {−341, 1024, −1024, 341}. With j=k−4, phase k outputs round((4096·C0 + 512·j·C1 + 64·j²·C2 + 8·j³·C3) / 2^23).
- R6: Phase 0 reproduces the input delayed by one sample. For an impulse of amplitude 1000 followed by zeros, phase 0 reads 0, 1000, 0, 0 over the four bursts.
- R7: Phase 4 (d=0) equals round(C0/2048). The offset weights add nothing there.
- R8: A constant input held for four or more samples appears unchanged on all eight phases.
- R9: Rounding is half-up, that is floor(v + 1/2). The result saturates to the range −32768..32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_sample | input | 16 | Signed two's-complement input sample |
| in_ready | output | 1 | Block can take a sample this cycle |
| out_valid | output | 1 | `out_sample` holds an interpolated value |
| out_phase | output | 3 | Index k of the phase being presented |
| out_sample | output | 16 | Signed interpolated output, saturated |

## Verification
The bound checker watches the handshake and burst sequencing on every cycle. It checks that an accept opens a burst at phase 0, that the phase steps by one up to 7 and then hands back to ready, that input during a burst does not break the burst, and that reset leaves the block idle. The arithmetic can only be shown by the bench scenarios: the exact sample values, the one-sample delay at phase 0, the C0-only phase 4, DC transparency, and rounding and saturation. The bench compares every emitted sample against its own integer evaluation of the filter formula over impulses, DC levels, extreme alternating patterns, a small-amplitude sweep and random data.

// File: rtl/farrow_x8_pkg.sv
package farrow_x8_pkg;
    localparam int PHASES  = 8;
    localparam int PH_W    = $clog2(PHASES);
    localparam int TAPS    = 4;
    localparam int POWERS  = 4;
    localparam int COEF_SH = 11;   // bank coefficient scale 2^11
    localparam int FRAC_SH = 20;   // combined scale after dropping common factor 8

    typedef enum logic [0:0] {
        LOAD_WAIT = 1'b0,
        BURST     = 1'b1
    } fsm_state_t;
endpackage

// File: rtl/farrow_x8_mulblk.sv
// Shared shift-and-add block: every bank constant times the input sample.
module farrow_x8_mulblk #(
    parameter int IN_W = 16,
    parameter int PW   = IN_W + 13
) (
    input  logic signed [IN_W-1:0] x,
    output logic signed [PW-1:0]   k128,
    output logic signed [PW-1:0]   k512,
    output logic signed [PW-1:0]   k1024,
    output logic signed [PW-1:0]   k1152,
    output logic signed [PW-1:0]   k2304,
    output logic signed [PW-1:0]   k85,
    output logic signed [PW-1:0]   k341
);
    logic signed [PW-1:0] xe, x5, x9;

    always_comb begin
        xe    = {{(PW-IN_W){x[IN_W-1]}}, x};
        x5    = (xe <<< 2) + xe;          // 5x
        x9    = (xe <<< 3) + xe;          // 9x
        k85   = (x5 <<< 4) + x5;          // 80x + 5x
        k341  = (xe <<< 8) + k85;         // 256x + 85x
        k1152 = x9 <<< 7;
        k2304 = x9 <<< 8;
        k128  = xe <<< 7;
        k512  = xe <<< 9;
        k1024 = xe <<< 10;
    end
endmodule

// File: rtl/farrow_x8_bank.sv
// Four transposed-form 4-tap subfilters fed by one product set.
module farrow_x8_bank #(
    parameter int PW = 29,
    parameter int CW = PW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [PW-1:0] k128,
    input  logic signed [PW-1:0] k512,
    input  logic signed [PW-1:0] k1024,
    input  logic signed [PW-1:0] k1152,
    input  logic signed [PW-1:0] k2304,
    input  logic signed [PW-1:0] k85,
    input  logic signed [PW-1:0] k341,
    output logic signed [CW-1:0] c_q [farrow_x8_pkg::POWERS]
);
    import farrow_x8_pkg::*;

    logic signed [PW-1:0] p [POWERS][TAPS];

    always_comb begin
        p[0][0] = -k128;  p[0][1] =  k1152; p[0][2] =  k1152; p[0][3] = -k128;
        p[1][0] =  k85;   p[1][1] = -k2304; p[1][2] =  k2304; p[1][3] = -k85;
        p[2][0] =  k512;  p[2][1] = -k512;  p[2][2] = -k512;  p[2][3] =  k512;
        p[3][0] = -k341;  p[3][1] =  k1024; p[3][2] = -k1024; p[3][3] =  k341;
    end

    for (genvar m = 0; m < POWERS; m++) begin : g_sub
        logic signed [CW-1:0] pe [TAPS];
        logic signed [CW-1:0] s_q [TAPS-1];

        for (genvar n = 0; n < TAPS; n++) begin : g_ext
            assign pe[n] = {{(CW-PW){p[m][n][PW-1]}}, p[m][n]};
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                c_q[m] <= '0;
                for (int i = 0; i < TAPS-1; i++) s_q[i] <= '0;
            end else if (load) begin
                c_q[m] <= pe[0] + s_q[0];
                for (int i = 0; i < TAPS-2; i++) s_q[i] <= pe[i+1] + s_q[i+1];
                s_q[TAPS-2] <= pe[TAPS-1];
            end
        end
    end
endmodule

// File: rtl/farrow_x8_weigh.sv
// Applies the phase weights d, d^2, d^3 by shift-and-add selection, then rounds and saturates.
module farrow_x8_weigh #(
    parameter int CW    = 31,
    parameter int OUT_W = 16
) (
    input  logic signed [CW-1:0]               c0,
    input  logic signed [CW-1:0]               c1,
    input  logic signed [CW-1:0]               c2,
    input  logic signed [CW-1:0]               c3,
    input  logic [farrow_x8_pkg::PH_W-1:0]     phase,
    output logic signed [OUT_W-1:0]            y
);
    import farrow_x8_pkg::*;

    localparam int ACC_W = CW + 12;
    localparam logic signed [ACC_W-1:0] HALF  = {{(ACC_W-1){1'b0}}, 1'b1} <<< (FRAC_SH-1);
    localparam logic signed [ACC_W-1:0] MAXV  = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV  = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [ACC_W-1:0] e0, e1, e2, e3;
    logic signed [ACC_W-1:0] e1x3, e2x9, e3x3, e3x27;
    logic signed [ACC_W-1:0] t1, t2, t3, acc, q;

    always_comb begin
        e0 = {{(ACC_W-CW){c0[CW-1]}}, c0};
        e1 = {{(ACC_W-CW){c1[CW-1]}}, c1};
        e2 = {{(ACC_W-CW){c2[CW-1]}}, c2};
        e3 = {{(ACC_W-CW){c3[CW-1]}}, c3};
        e1x3  = (e1 <<< 1) + e1;
        e2x9  = (e2 <<< 3) + e2;
        e3x3  = (e3 <<< 1) + e3;
        e3x27 = (e3x3 <<< 3) + e3x3;

        // phase k -> j = k - 4
        unique case (phase)
            3'd0: begin t1 = -(e1 <<< 2); t2 = e2 <<< 4; t3 = -(e3 <<< 6); end
            3'd1: begin t1 = -e1x3;       t2 = e2x9;     t3 = -e3x27;      end
            3'd2: begin t1 = -(e1 <<< 1); t2 = e2 <<< 2; t3 = -(e3 <<< 3); end
            3'd3: begin t1 = -e1;         t2 = e2;       t3 = -e3;         end
            3'd4: begin t1 = '0;          t2 = '0;       t3 = '0;          end
            3'd5: begin t1 = e1;          t2 = e2;       t3 = e3;          end
            3'd6: begin t1 = e1 <<< 1;    t2 = e2 <<< 2; t3 = e3 <<< 3;    end
            3'd7: begin t1 = e1x3;        t2 = e2x9;     t3 = e3x27;       end
            default: begin t1 = '0;       t2 = '0;       t3 = '0;          end
        endcase

        acc = (e0 <<< 9) + (t1 <<< 6) + (t2 <<< 3) + t3 + HALF;
        q   = acc >>> FRAC_SH;
        if (q > MAXV)      y = MAXV[OUT_W-1:0];
        else if (q < MINV) y = MINV[OUT_W-1:0];
        else               y = q[OUT_W-1:0];
    end
endmodule

// File: rtl/farrow_x8_interp.sv
module farrow_x8_interp #(
    parameter int IN_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic signed [IN_W-1:0]               in_sample,
    output logic                                 in_ready,
    output logic                                 out_valid,
    output logic [farrow_x8_pkg::PH_W-1:0]       out_phase,
    output logic signed [IN_W-1:0]               out_sample
);
    import farrow_x8_pkg::*;

    localparam int PW = IN_W + 13;
    localparam int CW = PW + 2;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    fsm_state_t       state_q;
    logic [PH_W-1:0]  phase_q;
    logic             accept;

    logic signed [PW-1:0] k128, k512, k1024, k1152, k2304, k85, k341;
    logic signed [CW-1:0] c_q [POWERS];

    assign accept = in_valid && (state_q == LOAD_WAIT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LOAD_WAIT;
            phase_q <= '0;
        end else begin
            unique case (state_q)
                LOAD_WAIT: if (accept) begin      // accept
                    state_q <= BURST;
                    phase_q <= '0;
                end
                BURST: if (phase_q == LAST_PH) begin   // drain
                    state_q <= LOAD_WAIT;
                    phase_q <= '0;
                end else begin                          // step
                    phase_q <= phase_q + 1'b1;
                end
                default: state_q <= LOAD_WAIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LOAD_WAIT: begin in_ready = 1'b1; out_valid = 1'b0; end
            BURST:     begin in_ready = 1'b0; out_valid = 1'b1; end
            default:   begin in_ready = 1'b0; out_valid = 1'b0; end
        endcase
        out_phase = phase_q;
    end

    farrow_x8_mulblk #(.IN_W(IN_W), .PW(PW)) u_mul (
        .x(in_sample), .k128(k128), .k512(k512), .k1024(k1024),
        .k1152(k1152), .k2304(k2304), .k85(k85), .k341(k341)
    );

    farrow_x8_bank #(.PW(PW), .CW(CW)) u_bank (
        .clk(clk), .rst(rst), .load(accept),
        .k128(k128), .k512(k512), .k1024(k1024),
        .k1152(k1152), .k2304(k2304), .k85(k85), .k341(k341),
        .c_q(c_q)
    );

    farrow_x8_weigh #(.CW(CW), .OUT_W(IN_W)) u_weigh (
        .c0(c_q[0]), .c1(c_q[1]), .c2(c_q[2]), .c3(c_q[3]),
        .phase(phase_q), .y(out_sample)
    );
endmodule

// File: rtl/farrow_x8_chk.sv
module farrow_x8_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic [2:0] out_phase
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    // R2
    accept_opens_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !in_ready && out_phase == 3'd0));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_phase != 3'd7) |=> (out_valid && out_phase == $past(out_phase) + 3'd1));

    // R3
    burst_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_phase == 3'd7) |=> (in_ready && !out_valid));

    // R4
    busy_input_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready && out_phase != 3'd7) |=> out_valid);
endmodule

bind farrow_x8_interp farrow_x8_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_phase(out_phase)
);

// File: tb/farrow_x8_interp_bench.sv
module farrow_x8_interp_bench;
    localparam int CLK_NS = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic              in_ready, out_valid;
    logic [2:0]        out_phase;
    logic signed [15:0] out_sample;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int hist [4];
    int got  [8];
    int coef [4][4];

    always #(CLK_NS/2) clk = ~clk;

    farrow_x8_interp u_farrow_x8_interp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .out_valid(out_valid),
        .out_phase(out_phase), .out_sample(out_sample)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint fdiv(longint a, longint b);
        longint q = a / b;
        if ((a % b != 0) && (a < 0)) q = q - 1;
        return q;
    endfunction

    function automatic int sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic longint cpow(int m);
        longint s = 0;
        for (int n = 0; n < 4; n++) s += longint'(coef[m][n]) * hist[n];
        return s;
    endfunction

    // R5: reference from the stated formula, scale 2^23
    function automatic int ref_out(int k);
        longint j = k - 4;
        longint acc = 4096 * cpow(0) + 512 * j * cpow(1)
                    + 64 * j * j * cpow(2) + 8 * j * j * j * cpow(3);
        return sat16(fdiv(acc + (64'sd1 <<< 22), 64'sd1 <<< 23));
    endfunction

    task automatic clear_hist();
        for (int n = 0; n < 4; n++) hist[n] = 0;
    endtask

    // called at a falling edge with the block idle
    task automatic send(int x, bit junk, string tag);
        chk(in_ready == 1'b1, "R2 ready when idle", in_ready, 1);
        in_valid  = 1'b1;
        in_sample = 16'(x);
        for (int n = 3; n > 0; n--) hist[n] = hist[n-1];
        hist[0] = x;
        @(negedge clk);
        if (!junk) in_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            int e = ref_out(k);
            chk(out_valid == 1'b1, "R3 out_valid in burst", out_valid, 1);
            chk(out_phase == 3'(k), "R3 phase order", out_phase, k);
            chk(in_ready == 1'b0, "R2 not ready in burst", in_ready, 0);
            chk(int'(out_sample) == e, tag, out_sample, e);
            got[k] = out_sample;
            if (junk) begin
                in_valid  = 1'b1;
                in_sample = 16'($urandom);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R3 burst ends after eight", out_valid, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        coef[0] = '{-128, 1152, 1152, -128};
        coef[1] = '{85, -2304, 2304, -85};
        coef[2] = '{512, -512, -512, 512};
        coef[3] = '{-341, 1024, -1024, 341};
        clear_hist();

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 no output after reset", out_valid, 0);

        // R6 / R7: impulse
        begin
            int imp0 [4] = '{0, 1000, 0, 0};
            int seq  [4] = '{1000, 0, 0, 0};
            for (int s = 0; s < 4; s++) begin
                longint c0;
                send(seq[s], 0, "R5 impulse");
                chk(got[0] == imp0[s], "R6 phase0 one-sample delay", got[0], imp0[s]);
                c0 = cpow(0);
                chk(got[4] == sat16(fdiv(c0 + 1024, 2048)), "R7 phase4 equals C0",
                    got[4], sat16(fdiv(c0 + 1024, 2048)));
            end
        end

        // R8: DC levels
        foreach (hist[i]) ;
        begin
            int lv [3] = '{12345, -32768, 32767};
            for (int l = 0; l < 3; l++) begin
                for (int s = 0; s < 5; s++) begin
                    send(lv[l], 0, "R5 dc");
                    if (s >= 3)
                        for (int k = 0; k < 8; k++)
                            chk(got[k] == lv[l], "R8 dc preserved", got[k], lv[l]);
                end
            end
        end

        // R9: extreme sign patterns drive saturation and rounding
        for (int pat = 0; pat < 16; pat++)
            for (int b = 0; b < 4; b++)
                send(pat[b] ? 32767 : -32768, 0, "R9 saturate/round");

        // R5: small-amplitude sweep
        for (int v = -64; v < 64; v++) send(v, 0, "R5 sweep");

        // R4: input toggling during bursts is ignored
        for (int s = 0; s < 200; s++) send(int'($signed(16'($urandom))), 1, "R4 busy input ignored");

        // R1: reset in the middle of a burst clears filter state
        in_valid = 1'b1; in_sample = 16'sd20000;
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1, "R1 ready after mid-burst reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 idle after mid-burst reset", out_valid, 0);
        clear_hist();
        send(1000, 0, "R1 state cleared");
        send(0, 0, "R1 state cleared");

        // R5: random full-scale data
        for (int s = 0; s < 2000; s++) send(int'($signed(16'($urandom))), 0, "R5 random");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule